// File: doc/BRIEF.md
# Round-Robin Packet Merge Bridge

This block joins several packet sources onto one wide packet sink. It drives the read enables of both sides. While the sink says it can take a whole packet, the bridge looks for a source that reports a packet ready. It searches in rotating order, starting one place after the source it served last. It locks onto the first source it finds and routes that source's words, start flag, end flag, empty-byte count and error flag to the sink. The lock lasts until an end-of-packet word moves with its valid flag high. The bridge then returns to searching.

A packet is never split or mixed with another source's words. The sink's space signal is looked at only when a new packet is chosen, so a drop in that signal during a packet does not halt the packet. When no source is ready, the bridge stays idle and its rotation pointer keeps its value.

Top module: `pkt_rr_merge`

## Requirements
- R1: While reset is held, every source read enable and the sink write enable are low.
- R2: While the sink space input (snk_dav_i) is low and no packet is locked, no source read enable goes high, whatever the sources report.
- R3: A new source is chosen one cycle after an edge at which the bridge is idle, snk_dav_i is high and some src_dav_i bit is high. The choice is the first ready source after the last served index, wrapping from the highest index back to 0. After reset the last served index is the highest one (NUM_SRC-1).
- R4: At most one src_ena_o bit is high, and it is the bit of the locked source. Bit n of each per-source bus belongs to source n. Source n's data occupies src_dat_i[n*128 +: 128] and its empty count occupies src_mty_i[n*4 +: 4].
- R5: While a source is locked, snk_dat_o, snk_sop_o, snk_eop_o, snk_mty_o and snk_err_o equal that source's inputs in the same cycle.
- R6: snk_ena_o is high exactly in the cycles where a source is locked and that source's src_val_i bit is high.
- R7: The lock holds through valid gaps, changes in src_dav_i and snk_dav_i, and end flags from sources that are not locked.
- R8: The lock ends after the first edge at which the locked source shows end and valid together. An end flag without valid does not end it. All read enables are low in the next cycle.
- R9: With snk_dav_i high and no source ready, the bridge stays idle and its rotation pointer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_dat_i | input | NUM_SRC*DATA_W | Source data words, one slice per source |
| src_dav_i | input | NUM_SRC | Source has a packet ready |
| src_val_i | input | NUM_SRC | Source word valid |
| src_sop_i | input | NUM_SRC | Source start of packet |
| src_eop_i | input | NUM_SRC | Source end of packet |
| src_mty_i | input | NUM_SRC*MTY_W | Source empty-byte counts |
| src_err_i | input | NUM_SRC | Source error flag |
| src_ena_o | output | NUM_SRC | Source read enables |
| snk_dav_i | input | 1 | Sink has room for a whole packet |
| snk_dat_o | output | DATA_W | Sink data word |
| snk_sop_o | output | 1 | Sink start of packet |
| snk_eop_o | output | 1 | Sink end of packet |
| snk_mty_o | output | MTY_W | Sink empty-byte count |
| snk_err_o | output | 1 | Sink error flag |
| snk_ena_o | output | 1 | Sink write enable |

## Verification
A table of ready masks is applied in sequence: all sources ready, two sources that are not next to each other, a lone high-index source, and a lone source 0. This separates a true rotating search from fixed priority and from a pointer that fails to wrap. A multi-word packet with valid gaps, an end flag held without valid, and other sources raising end flags shows that the lock follows only the chosen source's valid-qualified end. Idle periods with the sink not ready, and with no source ready, show that arbitration is gated correctly and that the pointer survives an empty search.

// File: rtl/pkt_rr_merge_pkg.sv
package pkt_rr_merge_pkg;
  typedef enum logic {
    LK_IDLE = 1'b0,
    LK_XFER = 1'b1
  } lock_st_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pkt_rr_pick.sv
module pkt_rr_pick #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned IDX_W   = pkt_rr_merge_pkg::idx_width(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [IDX_W-1:0]   last_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   pick_o
);
  // first requester strictly after last_i, wrapping
  always_comb begin
    int unsigned idx;
    any_o  = 1'b0;
    pick_o = last_i;
    for (int unsigned k = 1; k <= NUM_SRC; k++) begin
      idx = (int'(last_i) + k) % NUM_SRC;
      if (!any_o && req_i[IDX_W'(idx)]) begin
        any_o  = 1'b1;
        pick_o = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/pkt_rr_lock.sv
module pkt_rr_lock
  import pkt_rr_merge_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned IDX_W   = idx_width(NUM_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snk_dav_i,
  input  logic             any_i,
  input  logic [IDX_W-1:0] pick_i,
  input  logic             sel_val_i,
  input  logic             sel_eop_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] grant_o
);
  lock_st_e st_q;
  logic [IDX_W-1:0] grant_q;

  // grant_q doubles as the last-served pointer after release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= LK_IDLE;
      grant_q <= IDX_W'(NUM_SRC - 1);
    end else begin
      unique case (st_q)
        LK_IDLE: if (snk_dav_i && any_i) begin
          st_q    <= LK_XFER;
          grant_q <= pick_i;
        end
        LK_XFER: if (sel_val_i && sel_eop_i) st_q <= LK_IDLE;
        default: st_q <= LK_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q == LK_XFER);
  assign grant_o = grant_q;
endmodule

// File: rtl/pkt_rr_mux.sv
module pkt_rr_mux #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned DATA_W  = 128,
  parameter int unsigned MTY_W   = 4,
  parameter int unsigned IDX_W   = pkt_rr_merge_pkg::idx_width(NUM_SRC)
) (
  input  logic                       en_i,
  input  logic [IDX_W-1:0]           sel_i,
  input  logic [NUM_SRC*DATA_W-1:0]  dat_i,
  input  logic [NUM_SRC-1:0]         val_i,
  input  logic [NUM_SRC-1:0]         sop_i,
  input  logic [NUM_SRC-1:0]         eop_i,
  input  logic [NUM_SRC*MTY_W-1:0]   mty_i,
  input  logic [NUM_SRC-1:0]         err_i,
  output logic [NUM_SRC-1:0]         ena_o,
  output logic [DATA_W-1:0]          dat_o,
  output logic                       val_o,
  output logic                       sop_o,
  output logic                       eop_o,
  output logic [MTY_W-1:0]           mty_o,
  output logic                       err_o
);
  logic [DATA_W-1:0] dat_a [NUM_SRC];
  logic [MTY_W-1:0]  mty_a [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign dat_a[g] = dat_i[g*DATA_W +: DATA_W];
    assign mty_a[g] = mty_i[g*MTY_W +: MTY_W];
    assign ena_o[g] = en_i && (sel_i == IDX_W'(g));
  end

  always_comb begin
    dat_o = '0;
    val_o = 1'b0;
    sop_o = 1'b0;
    eop_o = 1'b0;
    mty_o = '0;
    err_o = 1'b0;
    if (en_i) begin
      dat_o = dat_a[sel_i];
      val_o = val_i[sel_i];
      sop_o = sop_i[sel_i];
      eop_o = eop_i[sel_i];
      mty_o = mty_a[sel_i];
      err_o = err_i[sel_i];
    end
  end
endmodule

// File: rtl/pkt_rr_merge.sv
module pkt_rr_merge
  import pkt_rr_merge_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned DATA_W  = 128,
  parameter int unsigned MTY_W   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC*DATA_W-1:0] src_dat_i,
  input  logic [NUM_SRC-1:0]        src_dav_i,
  input  logic [NUM_SRC-1:0]        src_val_i,
  input  logic [NUM_SRC-1:0]        src_sop_i,
  input  logic [NUM_SRC-1:0]        src_eop_i,
  input  logic [NUM_SRC*MTY_W-1:0]  src_mty_i,
  input  logic [NUM_SRC-1:0]        src_err_i,
  output logic [NUM_SRC-1:0]        src_ena_o,
  input  logic                      snk_dav_i,
  output logic [DATA_W-1:0]         snk_dat_o,
  output logic                      snk_sop_o,
  output logic                      snk_eop_o,
  output logic [MTY_W-1:0]          snk_mty_o,
  output logic                      snk_err_o,
  output logic                      snk_ena_o
);
  localparam int unsigned IDX_W = idx_width(NUM_SRC);

  logic             any_rdy;
  logic [IDX_W-1:0] pick_idx;
  logic [IDX_W-1:0] grant_idx;
  logic             busy;
  logic             sel_val;
  logic             sel_eop;

  pkt_rr_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) pick_i (
    .req_i  (src_dav_i),
    .last_i (grant_idx),
    .any_o  (any_rdy),
    .pick_o (pick_idx)
  );

  pkt_rr_lock #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) lock_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .snk_dav_i (snk_dav_i),
    .any_i     (any_rdy),
    .pick_i    (pick_idx),
    .sel_val_i (sel_val),
    .sel_eop_i (sel_eop),
    .busy_o    (busy),
    .grant_o   (grant_idx)
  );

  pkt_rr_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .MTY_W(MTY_W), .IDX_W(IDX_W)) mux_i (
    .en_i  (busy),
    .sel_i (grant_idx),
    .dat_i (src_dat_i),
    .val_i (src_val_i),
    .sop_i (src_sop_i),
    .eop_i (src_eop_i),
    .mty_i (src_mty_i),
    .err_i (src_err_i),
    .ena_o (src_ena_o),
    .dat_o (snk_dat_o),
    .val_o (sel_val),
    .sop_o (snk_sop_o),
    .eop_o (sel_eop),
    .mty_o (snk_mty_o),
    .err_o (snk_err_o)
  );

  assign snk_eop_o = sel_eop;
  assign snk_ena_o = sel_val;
endmodule

// File: rtl/pkt_rr_merge_chk.sv
module pkt_rr_merge_chk #(
  parameter int unsigned NUM_SRC = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_dav_i,
  input logic [NUM_SRC-1:0] src_val_i,
  input logic [NUM_SRC-1:0] src_ena_o,
  input logic               snk_dav_i,
  input logic               snk_ena_o,
  input logic               snk_eop_o
);
  p_ena_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_ena_o));

  p_snk_ena_val_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snk_ena_o == |(src_ena_o & src_val_i));

  p_gate_sink_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ena_o == '0 && !snk_dav_i) |=> src_ena_o == '0);

  p_grant_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ena_o == '0) |=> (src_ena_o == '0 || |($past(src_dav_i) & src_ena_o)));

  p_hold_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ena_o != '0 && !(snk_ena_o && snk_eop_o)) |=> src_ena_o == $past(src_ena_o));

  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snk_ena_o && snk_eop_o) |=> src_ena_o == '0);

  p_stay_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ena_o == '0 && src_dav_i == '0) |=> src_ena_o == '0);
endmodule

bind pkt_rr_merge pkt_rr_merge_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_dav_i (src_dav_i),
  .src_val_i (src_val_i),
  .src_ena_o (src_ena_o),
  .snk_dav_i (snk_dav_i),
  .snk_ena_o (snk_ena_o),
  .snk_eop_o (snk_eop_o)
);

// File: tb/pkt_rr_merge_tb_top.sv
module pkt_rr_merge_tb_top;
  localparam int N  = 4;
  localparam int DW = 128;
  localparam int MW = 4;

  // {ready mask, expected index}
  localparam logic [5:0] VEC [8] = '{
    {4'b1111, 2'd0}, {4'b1111, 2'd1}, {4'b0101, 2'd2}, {4'b0101, 2'd0},
    {4'b1000, 2'd3}, {4'b0110, 2'd1}, {4'b0110, 2'd2}, {4'b0001, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [DW-1:0] b_dat [N];
  logic [MW-1:0] b_mty [N];
  logic [N*DW-1:0] src_dat;
  logic [N*MW-1:0] src_mty;
  logic [N-1:0] src_dav, src_val, src_sop, src_eop, src_err, src_ena;
  logic snk_dav, snk_sop, snk_eop, snk_err, snk_ena;
  logic [DW-1:0] snk_dat;
  logic [MW-1:0] snk_mty;

  always_comb
    for (int i = 0; i < N; i++) begin
      src_dat[i*DW +: DW] = b_dat[i];
      src_mty[i*MW +: MW] = b_mty[i];
    end

  pkt_rr_merge #(.NUM_SRC(N), .DATA_W(DW), .MTY_W(MW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .src_dat_i(src_dat), .src_dav_i(src_dav), .src_val_i(src_val),
    .src_sop_i(src_sop), .src_eop_i(src_eop), .src_mty_i(src_mty),
    .src_err_i(src_err), .src_ena_o(src_ena),
    .snk_dav_i(snk_dav), .snk_dat_o(snk_dat), .snk_sop_o(snk_sop),
    .snk_eop_o(snk_eop), .snk_mty_o(snk_mty), .snk_err_o(snk_err),
    .snk_ena_o(snk_ena)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [DW-1:0] word(int s, int n);
    return {32'(s + 1), 64'h0123_4567_89ab_cdef, 32'(n)};
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // every source presents word n with the given flags
  task automatic drive_all(logic v, logic so, logic eo, int n);
    for (int s = 0; s < N; s++) begin
      b_dat[s] = word(s, n);
      b_mty[s] = MW'(s + 5);
    end
    src_val = {N{v}};
    src_sop = {N{so}};
    src_eop = {N{eo}};
    src_err = 4'b1010;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    drive_all(1'b1, 1'b1, 1'b1, 0);
    src_dav = '1;
    snk_dav = 1'b1;
    repeat (3) tick();
    chk("R1 src_ena", DW'(src_ena), '0);
    chk("R1 snk_ena", DW'(snk_ena), '0);
    rst_n = 1'b1;

    // R2: sink not ready
    snk_dav = 1'b0;
    repeat (3) tick();
    chk("R2 no grant", DW'(src_ena), '0);
    src_dav = '0;
    snk_dav = 1'b1;
    tick();

    // R3 table walk
    for (int v = 0; v < 8; v++) begin
      src_dav = VEC[v][5:2];
      drive_all(1'b0, 1'b0, 1'b0, v);
      #1;
      chk("R3 idle before edge", DW'(src_ena), '0);
      tick();
      src_dav = '0;
      drive_all(1'b1, 1'b1, 1'b1, v);
      #1;
      chk("R3 R4 grant", DW'(src_ena), DW'(4'b0001 << VEC[v][1:0]));
      chk("R6 snk_ena", DW'(snk_ena), DW'(1));
      chk("R5 data", snk_dat, word(int'(VEC[v][1:0]), v));
      chk("R5 mty", DW'(snk_mty), DW'(VEC[v][1:0] + 5));
      chk("R5 err", DW'(snk_err), DW'(VEC[v][0]));
      tick();
      drive_all(1'b0, 1'b0, 1'b0, v);
      #1;
      chk("R8 release", DW'(src_ena), '0);
    end

    // R9: nothing ready, pointer held at 0
    repeat (3) tick();
    chk("R9 idle", DW'(src_ena), '0);
    src_dav = '1;
    tick();
    chk("R9 pointer kept", DW'(src_ena), DW'(4'b0010));

    // R7: multi-word packet on source 1 with disturbances
    src_dav = 4'b1101;
    snk_dav = 1'b0;
    drive_all(1'b1, 1'b1, 1'b1, 10);
    src_eop[1] = 1'b0;
    #1;
    chk("R5 sop", DW'(snk_sop), DW'(1));
    chk("R5 word0", snk_dat, word(1, 10));
    tick();
    drive_all(1'b0, 1'b0, 1'b1, 11);
    src_eop[1] = 1'b0;
    #1;
    chk("R6 gap", DW'(snk_ena), '0);
    chk("R7 hold in gap", DW'(src_ena), DW'(4'b0010));
    tick();
    drive_all(1'b1, 1'b0, 1'b1, 12);
    src_eop[1] = 1'b0;
    #1;
    chk("R5 word2", snk_dat, word(1, 12));
    tick();
    chk("R7 others eop", DW'(src_ena), DW'(4'b0010));
    drive_all(1'b0, 1'b0, 1'b1, 13);
    tick();
    chk("R8 eop no val", DW'(src_ena), DW'(4'b0010));
    drive_all(1'b1, 1'b0, 1'b1, 14);
    #1;
    chk("R5 eop", DW'(snk_eop), DW'(1));
    chk("R5 mty last", DW'(snk_mty), DW'(6));
    tick();
    drive_all(1'b0, 1'b0, 1'b0, 15);
    #1;
    chk("R8 released", DW'(src_ena), '0);
    tick();
    tick();
    chk("R2 after packet", DW'(src_ena), '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule